// File: doc/BRIEF.md
# Shift-and-Add Address Unit

This block forms 32-bit scaled-index sums of the kind used to build memory addresses. A single shifter feeding a single adder serves two operation families. In the scaled-add family, the first operand is shifted left by a 5-bit amount and the second operand is added to it. Either operand may be negated in two's complement before the shift and the add. In the effective-address family, the result is a base plus an index shifted left by the same amount. A form code selects where the base and the index come from, and which of them the negate controls may touch.

All arithmetic wraps modulo 2^32. One operation is accepted per cycle when `in_valid` is high. The result is registered and appears with `res_valid` one clock later.

The scaled-add family cannot produce condition flags. If flags are requested in that family, the block still returns the sum and raises `res_unsupported` beside it.

Top module: `addr_unit`

## Requirements
- R1: After reset, `res_valid`, `res_unsupported` and `res_data` are all 0.
- R2: An operation presented with `in_valid`=1 is reported with `res_valid`=1 in the next cycle. In a cycle after `in_valid`=0, `res_valid` is 0 and `res_data` keeps its last value.
- R3: With `mode`=0 (scaled-add), `res_data` = (`reg_a` << `shamt`) + `reg_b`, modulo 2^32.
- R4: In scaled-add, `neg_a`=1 replaces `reg_a` by its two's complement before the shift. `neg_b`=1 replaces `reg_b` by its two's complement before the add.
- R5: With `mode`=1 and `form`=0, `res_data` = `reg_a` + (`reg_b` << `shamt`). Both negate controls are ignored.
- R6: With `mode`=1 and `form`=1, `res_data` = (`neg_a` ? -`reg_a` : `reg_a`) + (`reg_b` << `shamt`). `neg_b` is ignored.
- R7: With `mode`=1 and `form`=2, the base is `imm_field` zero-extended to 32 bits. `res_data` = base + ((`neg_b` ? -`reg_b` : `reg_b`) << `shamt`). `neg_a` is ignored.
- R8: With `mode`=1 and `form`=3, `res_data` = `const_val` + ((`neg_b` ? -`reg_b` : `reg_b`) << `shamt`). `neg_a` is ignored.
- R9: `res_unsupported` is 1 exactly when the reported operation had `mode`=0 and `flags_en`=1. It is 0 for any `mode`=1 operation, whatever `flags_en` is.
- R10: In scaled-add, the `form` input has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| mode | input | 1 | 0 = scaled-add, 1 = effective-address |
| form | input | 2 | Effective-address operand routing: 0 two registers, 1 negatable register base, 2 immediate base, 3 constant base |
| reg_a | input | 32 | First register operand |
| reg_b | input | 32 | Second register operand |
| imm_field | input | 20 | Immediate base field, zero-extended |
| const_val | input | 32 | Constant-input base value |
| shamt | input | 5 | Shift amount, 0 to 31 |
| neg_a | input | 1 | Negate control for the first operand |
| neg_b | input | 1 | Negate control for the second operand |
| flags_en | input | 1 | Condition-flag request |
| res_valid | output | 1 | Result valid |
| res_data | output | 32 | Registered 32-bit result |
| res_unsupported | output | 1 | Flags were requested in scaled-add |

## Verification
The hardest case to reach from the ports is showing that a negate control has no effect. A wrong routing that negates the unprotected operand only shows up when that operand is nonzero and the ignored control is set. The stimulus therefore sets both negate controls on every effective-address form, and uses operand values whose negated result differs visibly from the correct sum. Wrap-around is reached by shifting a top-set operand by 31, or by adding into a value near 2^32.

// File: rtl/addr_unit_pkg.sv
package addr_unit_pkg;

    typedef enum logic {
        MODE_SCALED = 1'b0,
        MODE_EA     = 1'b1
    } au_mode_e;

    typedef enum logic [1:0] {
        FORM_RR    = 2'd0,
        FORM_RNEG  = 2'd1,
        FORM_IMM   = 2'd2,
        FORM_CONST = 2'd3
    } au_form_e;

endpackage

// File: rtl/addr_operand_route.sv
module addr_operand_route
    import addr_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 20
) (
    input  logic              mode,
    input  logic [1:0]        form,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [DATA_W-1:0] const_val,
    input  logic              neg_a,
    input  logic              neg_b,
    output logic [DATA_W-1:0] base_o,
    output logic [DATA_W-1:0] index_o
);

    logic [DATA_W-1:0] a_signed;
    logic [DATA_W-1:0] b_signed;
    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        a_signed = neg_a ? (DATA_W'(0) - reg_a) : reg_a;
        b_signed = neg_b ? (DATA_W'(0) - reg_b) : reg_b;
        imm_ext  = {{(DATA_W-IMM_W){1'b0}}, imm_field};
    end

    always_comb begin
        base_o  = reg_a;
        index_o = reg_b;
        if (au_mode_e'(mode) == MODE_SCALED) begin
            // scaled-add: first operand is shifted, second is added
            base_o  = b_signed;
            index_o = a_signed;
        end else begin
            unique case (au_form_e'(form))
                FORM_RR: begin
                    base_o  = reg_a;
                    index_o = reg_b;
                end
                FORM_RNEG: begin
                    base_o  = a_signed;
                    index_o = reg_b;
                end
                FORM_IMM: begin
                    base_o  = imm_ext;
                    index_o = b_signed;
                end
                FORM_CONST: begin
                    base_o  = const_val;
                    index_o = b_signed;
                end
                default: begin
                    base_o  = reg_a;
                    index_o = reg_b;
                end
            endcase
        end
    end

endmodule

// File: rtl/addr_shift_add.sv
module addr_shift_add #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] index_i,
    input  logic [SH_W-1:0]   shamt_i,
    output logic [DATA_W-1:0] sum_o
);

    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = index_i << shamt_i;
        sum_o   = base_i + shifted;
    end

endmodule

// File: rtl/addr_unit.sv
module addr_unit
    import addr_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 20,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [1:0]        form,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [DATA_W-1:0] const_val,
    input  logic [SH_W-1:0]   shamt,
    input  logic              neg_a,
    input  logic              neg_b,
    input  logic              flags_en,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_unsupported
);

    typedef struct packed {
        logic              valid;
        logic              unsup;
        logic [DATA_W-1:0] data;
    } au_state_t;

    au_state_t st_d, st_q;

    logic [DATA_W-1:0] base_w;
    logic [DATA_W-1:0] index_w;
    logic [DATA_W-1:0] sum_w;

    addr_operand_route #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_route (
        .mode      (mode),
        .form      (form),
        .reg_a     (reg_a),
        .reg_b     (reg_b),
        .imm_field (imm_field),
        .const_val (const_val),
        .neg_a     (neg_a),
        .neg_b     (neg_b),
        .base_o    (base_w),
        .index_o   (index_w)
    );

    addr_shift_add #(
        .DATA_W (DATA_W),
        .SH_W   (SH_W)
    ) u_shadd (
        .base_i  (base_w),
        .index_i (index_w),
        .shamt_i (shamt),
        .sum_o   (sum_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.unsup = 1'b0;
        if (in_valid) begin
            st_d.data  = sum_w;
            st_d.unsup = (au_mode_e'(mode) == MODE_SCALED) && flags_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid       = st_q.valid;
    assign res_data        = st_q.data;
    assign res_unsupported = st_q.unsup;

    // R2: accepted operation reported next cycle
    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // R2: idle cycle keeps result
    a_r2_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(res_data)));

    // R9: effective-address never flagged
    a_r9_ea_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |=> !res_unsupported);

    // R9: flag only rides on a valid result
    a_r9_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_unsupported |-> res_valid);

    // R9: scaled-add with flag request is reported
    a_r9_scaled_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode && flags_en) |=> res_unsupported);

endmodule

// File: tb/addr_unit_bench.sv
module addr_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        mode;
    logic [1:0]  form;
    logic [31:0] reg_a, reg_b, const_val;
    logic [19:0] imm_field;
    logic [4:0]  shamt;
    logic        neg_a, neg_b, flags_en;
    logic        res_valid;
    logic [31:0] res_data;
    logic        res_unsupported;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    addr_unit u_addr_unit (
        .clk             (clk),
        .rst_n           (rst_n),
        .in_valid        (in_valid),
        .mode            (mode),
        .form            (form),
        .reg_a           (reg_a),
        .reg_b           (reg_b),
        .imm_field       (imm_field),
        .const_val       (const_val),
        .shamt           (shamt),
        .neg_a           (neg_a),
        .neg_b           (neg_b),
        .flags_en        (flags_en),
        .res_valid       (res_valid),
        .res_data        (res_data),
        .res_unsupported (res_unsupported)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // drive at negedge, result registered at next posedge, sample at next negedge
    task automatic issue(input logic m, input logic [1:0] f, input logic [31:0] a,
                         input logic [31:0] b, input logic [19:0] imm, input logic [31:0] cst,
                         input logic [4:0] sh, input logic na, input logic nb, input logic fl);
        mode = m; form = f; reg_a = a; reg_b = b; imm_field = imm; const_val = cst;
        shamt = sh; neg_a = na; neg_b = nb; flags_en = fl; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 valid", {31'd0, res_valid}, 32'd0);
        check("R1 data", res_data, 32'd0);
        check("R1 unsupported", {31'd0, res_unsupported}, 32'd0);
    endtask

    task automatic t_scaled();
        issue(1'b0, 2'd0, 32'd5, 32'd7, 20'd0, 32'd0, 5'd4, 1'b0, 1'b0, 1'b0);
        check("R3 basic", res_data, 32'h57);
        check("R2 valid", {31'd0, res_valid}, 32'd1);
        issue(1'b0, 2'd3, 32'h8000_0001, 32'd3, 20'hFFFFF, 32'h1234, 5'd1, 1'b0, 1'b0, 1'b0);
        check("R3 R10 wrap with form=3", res_data, 32'd5);
    endtask

    task automatic t_scaled_neg();
        issue(1'b0, 2'd0, 32'd1, 32'd100, 20'd0, 32'd0, 5'd3, 1'b1, 1'b0, 1'b0);
        check("R4 neg_a", res_data, 32'd92);
        issue(1'b0, 2'd2, 32'd2, 32'd5, 20'd0, 32'd0, 5'd0, 1'b0, 1'b1, 1'b0);
        check("R4 R10 neg_b", res_data, 32'hFFFF_FFFD);
    endtask

    task automatic t_hold();
        issue(1'b1, 2'd0, 32'd9, 32'd1, 20'd0, 32'd0, 5'd1, 1'b0, 1'b0, 1'b0);
        check("R2 data", res_data, 32'd11);
        @(negedge clk);
        check("R2 idle valid", {31'd0, res_valid}, 32'd0);
        check("R2 idle hold", res_data, 32'd11);
    endtask

    task automatic t_ea_forms();
        issue(1'b1, 2'd0, 32'h1000, 32'd3, 20'd0, 32'd0, 5'd2, 1'b1, 1'b1, 1'b0);
        check("R5 two-reg negs ignored", res_data, 32'h100C);
        issue(1'b1, 2'd1, 32'h10, 32'd1, 20'd0, 32'd0, 5'd8, 1'b1, 1'b1, 1'b0);
        check("R6 negated base", res_data, 32'd240);
        issue(1'b1, 2'd1, 32'h10, 32'd1, 20'd0, 32'd0, 5'd8, 1'b0, 1'b0, 1'b0);
        check("R6 plain base", res_data, 32'h110);
        issue(1'b1, 2'd2, 32'hDEAD, 32'd2, 20'hABCDE, 32'd0, 5'd4, 1'b1, 1'b1, 1'b0);
        check("R7 immediate base", res_data, 32'h000A_BCBE);
        issue(1'b1, 2'd3, 32'hBEEF, 32'd1, 20'd0, 32'hFFFF_0000, 5'd31, 1'b1, 1'b0, 1'b0);
        check("R8 const wrap", res_data, 32'h7FFF_0000);
        issue(1'b1, 2'd3, 32'd0, 32'd1, 20'd0, 32'h1000, 5'd4, 1'b0, 1'b1, 1'b0);
        check("R8 const neg index", res_data, 32'h0FF0);
    endtask

    task automatic t_flags();
        issue(1'b0, 2'd0, 32'd1, 32'd1, 20'd0, 32'd0, 5'd0, 1'b0, 1'b0, 1'b1);
        check("R9 scaled flag", {31'd0, res_unsupported}, 32'd1);
        check("R9 scaled result", res_data, 32'd2);
        issue(1'b1, 2'd0, 32'd1, 32'd1, 20'd0, 32'd0, 5'd0, 1'b0, 1'b0, 1'b1);
        check("R9 ea no flag", {31'd0, res_unsupported}, 32'd0);
        issue(1'b0, 2'd0, 32'd1, 32'd1, 20'd0, 32'd0, 5'd0, 1'b0, 1'b0, 1'b0);
        check("R9 scaled no request", {31'd0, res_unsupported}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; mode = 1'b0; form = 2'd0; reg_a = '0; reg_b = '0;
        imm_field = '0; const_val = '0; shamt = '0; neg_a = 1'b0; neg_b = 1'b0; flags_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scaled();
        t_scaled_neg();
        t_hold();
        t_ea_forms();
        t_flags();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule